// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Interrupt Detection

This peripheral drives and samples sixteen general-purpose pins from a simple synchronous register bus carrying 16-bit words. Each pin is independently an input or an output. The output latch can be written in full. It can also be changed through a set-only port and a clear-only port, so that one pin can be updated without a read-modify-write sequence.

Every pin is brought into the clock domain through a two-stage synchronizer. It can then raise an interrupt in one of two ways. In level mode the pin is active while it sits at a chosen level. In edge mode the controller latches a rising edge, a falling edge, or either edge. Latched edge flags stay set until software acknowledges them with a write-one-to-clear access. A per-pin mask and a per-pin enable together decide which pending pins are forwarded. The forwarded pins are ORed into one interrupt line. Software reads the pin state, the raw status and the forwarded status over the same bus.

Top module: `gpio_ctl`

## Requirements
- R1: After reset the mask register reads 0xFFFF. Direction, output latch, level-select, polarity, rising enable, falling enable, interrupt enable and all edge flags read 0, and `irq` is low.
- R2: The direction register at address 0x00 is readable. It drives `pin_oe` directly: bit value 1 makes that pin an output and 0 makes it an input.
- R3: A write to 0x18 sets every output-latch bit whose written bit is 1. A write to 0x1C clears every output-latch bit whose written bit is 1. Written 0 bits leave the latch unchanged. The latch reads at 0x20, is writable as a whole at 0x20, and drives `pin_out`.
- R4: Address 0x14 returns the pin inputs after a two-flop synchronizer. A pin change shows there from the second rising clock edge after the change.
- R5: Address 0x04 selects the mode per pin: 1 is level mode and 0 is edge mode. In level mode, address 0x08 sets the polarity: 1 is active-high and 0 is active-low. The pin's raw status bit, read at 0x24, follows the synchronized level and is not latched.
- R6: In edge mode, the rising enable at 0x0C and the falling enable at 0x10 act independently. A synchronized 0-to-1 transition latches the pin's flag when the rising enable is set. A 1-to-0 transition latches it when the falling enable is set. With both enables set, either edge latches the flag. The flag shows in the raw status at 0x24.
- R7: Address 0x30 returns the raw status ANDed with the inverse of the mask at 0x28 and with the interrupt enable at 0x2C.
- R8: `irq` is high exactly when any bit of the masked status is 1.
- R9: A write to 0x34 clears each edge flag whose written bit is 1. Written 0 bits have no effect. The write does not change the status of a pin in level mode.
- R10: When an edge is detected on a pin in the same cycle as a clear write with that pin's bit set, the flag stays set.
- R11: Reads return 0 when `bus_rd` is low. They also return 0 at unmapped addresses and at the write-only addresses 0x18, 0x1C and 0x34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, applied at the rising edge |
| bus_rd | input | 1 | Read strobe, gates read data |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Output latch value |
| pin_oe | output | 16 | Per-pin output enable (direction) |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions of this block can act in the same cycle: the edge detector setting a flag, and a software clear write to the same flag. To provoke the collision, the bench first latches a flag. It then toggles the pin so that the synchronized transition appears exactly in the cycle when a clear write carrying that pin's bit is applied. The test passes if the raw status still shows the flag after that cycle, because the new edge must win. A later clear write with no edge pending must then empty the flag, which confirms that the clear path itself works.

// File: rtl/gpio_ctl.sv
module gpio_ctl #(
  parameter int N  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic          irq
);
  localparam logic [AW-1:0] A_DIR  = AW'('h00);
  localparam logic [AW-1:0] A_LSEL = AW'('h04);
  localparam logic [AW-1:0] A_LPOL = AW'('h08);
  localparam logic [AW-1:0] A_RISE = AW'('h0C);
  localparam logic [AW-1:0] A_FALL = AW'('h10);
  localparam logic [AW-1:0] A_DIN  = AW'('h14);
  localparam logic [AW-1:0] A_SET  = AW'('h18);
  localparam logic [AW-1:0] A_CLR  = AW'('h1C);
  localparam logic [AW-1:0] A_DOUT = AW'('h20);
  localparam logic [AW-1:0] A_RAW  = AW'('h24);
  localparam logic [AW-1:0] A_MASK = AW'('h28);
  localparam logic [AW-1:0] A_IEN  = AW'('h2C);
  localparam logic [AW-1:0] A_MST  = AW'('h30);
  localparam logic [AW-1:0] A_ACK  = AW'('h34);

  logic [N-1:0] dir_q, lsel_q, lpol_q, rise_q, fall_q, dout_q, mask_q, ien_q, flag_q;
  logic [N-1:0] s1_q, s2_q, s3_q;
  logic [N-1:0] edge_hit, lvl_hit, raw_st, msk_st, ack_bits;

  assign edge_hit = ~lsel_q & ((rise_q & s2_q & ~s3_q) | (fall_q & ~s2_q & s3_q));
  assign lvl_hit  = lsel_q & ~(s2_q ^ lpol_q);
  assign raw_st   = lvl_hit | (~lsel_q & flag_q);
  assign msk_st   = raw_st & ~mask_q & ien_q;
  assign irq      = |msk_st;
  assign pin_out  = dout_q;
  assign pin_oe   = dir_q;
  assign ack_bits = (bus_wr && bus_addr == A_ACK) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~ack_bits) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lsel_q <= '0;
      lpol_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      dout_q <= '0;
      mask_q <= '1;
      ien_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DIR:  dir_q  <= bus_wdata;
        A_LSEL: lsel_q <= bus_wdata;
        A_LPOL: lpol_q <= bus_wdata;
        A_RISE: rise_q <= bus_wdata;
        A_FALL: fall_q <= bus_wdata;
        A_SET:  dout_q <= dout_q | bus_wdata;
        A_CLR:  dout_q <= dout_q & ~bus_wdata;
        A_DOUT: dout_q <= bus_wdata;
        A_MASK: mask_q <= bus_wdata;
        A_IEN:  ien_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_DIR:  bus_rdata = dir_q;
        A_LSEL: bus_rdata = lsel_q;
        A_LPOL: bus_rdata = lpol_q;
        A_RISE: bus_rdata = rise_q;
        A_FALL: bus_rdata = fall_q;
        A_DIN:  bus_rdata = s2_q;
        A_DOUT: bus_rdata = dout_q;
        A_RAW:  bus_rdata = raw_st;
        A_MASK: bus_rdata = mask_q;
        A_IEN:  bus_rdata = ien_q;
        A_MST:  bus_rdata = msk_st;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module gpio_ctl_chk #(
  parameter int N  = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  pin_out,
  input logic [N-1:0]  pin_oe,
  input logic          irq,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  ien_q,
  input logic [N-1:0]  flag_q,
  input logic [N-1:0]  edge_hit
);
  assert_dir_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h00)) |=> pin_oe == $past(bus_wdata));
  assert_set_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h18)) |=>
      ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));
  assert_clr_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h1C)) |=>
      ((pin_out & $past(bus_wdata)) == '0) &&
      ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ien_q & ~mask_q) != '0));
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h34)) |=>
      ((flag_q & $past(bus_wdata) & ~$past(edge_hit)) == '0));
  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));
endmodule

bind gpio_ctl gpio_ctl_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .mask_q(mask_q), .ien_q(ien_q), .flag_q(flag_q), .edge_hit(edge_hit)
);

// File: tb/sim_gpio_ctl.sv
`timescale 1ns/1ps
module sim_gpio_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_ctl u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rdchk(string req, logic [7:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [15:0] model, a, b, bit_p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdchk("R1", 8'h28, 16'hFFFF);
    foreach (a[i]) ;
    for (int k = 0; k < 12; k++) begin
      logic [7:0] ad;
      ad = (k < 5) ? 8'(k*4) : (k == 5) ? 8'h20 : (k == 6) ? 8'h2C : (k == 7) ? 8'h30 : (k == 8) ? 8'h24 : 8'h14;
      rdchk("R1", ad, 16'h0000);
    end
    chk("R1 irq", {15'd0, irq}, 16'd0);
    // R11 read strobe low and write-only addresses
    wr(8'h28, 16'h1234);
    @(negedge clk); bus_addr = 8'h28; #1 chk("R11 rd low", bus_rdata, 16'h0000);
    rdchk("R11 0x18", 8'h18, 16'h0); rdchk("R11 0x1C", 8'h1C, 16'h0);
    rdchk("R11 0x34", 8'h34, 16'h0); rdchk("R11 0x3C", 8'h3C, 16'h0);
    // R2 direction and R3 output sweeps
    model = '0;
    for (int k = 0; k < 40; k++) begin
      a = 16'((k * 16'h3A95) ^ (k << 7));
      b = 16'((k * 16'h1C07) ^ 16'h5A5A);
      wr(8'h00, a);
      chk("R2 pin_oe", pin_oe, a);
      rdchk("R2", 8'h00, a);
      wr(8'h18, a); model = model | a;
      chk("R3 set", pin_out, model);
      wr(8'h1C, b); model = model & ~b;
      chk("R3 clr", pin_out, model);
      rdchk("R3", 8'h20, model);
      if (k % 8 == 7) begin wr(8'h20, b); model = b; chk("R3 full", pin_out, model); end
    end
    // R4 synchronizer latency: change just before an edge
    @(negedge clk); pin_in = 16'hA5C3;
    @(posedge clk); #1 chk("R4 1 edge", u0.bus_rdata & 16'h0, 16'h0);
    bus_rd = 1'b1; bus_addr = 8'h14; #1 chk("R4 after 1", bus_rdata, 16'h0000);
    @(posedge clk); #1 chk("R4 after 2", bus_rdata, 16'hA5C3);
    bus_rd = 1'b0;
    pin_in = '0; settle();
    // R5..R9 sweep: every pin, every mode
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 5; m++) begin
        logic st;
        bit_p = 16'(1) << p;
        wr(8'h04, 16'h0); wr(8'h0C, 16'h0); wr(8'h10, 16'h0);
        st = (m == 1 || m == 3);       // m0 lvl-high m1 lvl-low m2 rise m3 fall m4 both
        pin_in = st ? bit_p : 16'h0;
        settle();
        wr(8'h34, 16'hFFFF);
        wr(8'h08, (m == 0) ? bit_p : 16'h0);
        if (m < 2) wr(8'h04, bit_p);
        if (m == 2 || m == 4) wr(8'h0C, bit_p);
        if (m >= 3) wr(8'h10, bit_p);
        wr(8'h28, ~bit_p); wr(8'h2C, bit_p);
        rdchk(m < 2 ? "R5 idle" : "R6 idle", 8'h24, 16'h0);
        chk("R8 idle", {15'd0, irq}, 16'd0);
        pin_in = st ? 16'h0 : bit_p;
        settle();
        rdchk(m < 2 ? "R5 active" : "R6 edge", 8'h24, bit_p);
        rdchk("R7", 8'h30, bit_p);
        chk("R8", {15'd0, irq}, 16'd1);
        wr(8'h28, 16'hFFFF);
        rdchk("R7 masked", 8'h30, 16'h0); chk("R8 masked", {15'd0, irq}, 16'd0);
        wr(8'h28, 16'h0); wr(8'h2C, ~bit_p);
        rdchk("R7 disabled", 8'h30, 16'h0); chk("R8 disabled", {15'd0, irq}, 16'd0);
        wr(8'h2C, bit_p);
        wr(8'h34, ~bit_p);
        rdchk("R9 zero bits", 8'h24, bit_p);
        if (m < 2) begin
          wr(8'h34, bit_p);
          rdchk("R9 level", 8'h24, bit_p);
          pin_in = st ? bit_p : 16'h0; settle();
          rdchk("R5 unlatched", 8'h24, 16'h0);
          chk("R8 release", {15'd0, irq}, 16'd0);
        end else begin
          pin_in = st ? bit_p : 16'h0; settle();
          rdchk("R6 held", 8'h24, bit_p);
          wr(8'h34, bit_p);
          rdchk("R9 cleared", 8'h24, 16'h0);
          chk("R8 cleared", {15'd0, irq}, 16'd0);
          if (m == 4) begin
            pin_in = bit_p; settle(); wr(8'h34, bit_p);
            pin_in = 16'h0; settle();
            rdchk("R6 both fall", 8'h24, bit_p);
          end else begin
            pin_in = st ? 16'h0 : bit_p; settle(); wr(8'h34, bit_p);
            pin_in = st ? bit_p : 16'h0; settle();
            rdchk("R6 wrong edge", 8'h24, 16'h0);
          end
        end
      end
    end
    // R10 edge and clear in the same cycle
    wr(8'h04, 16'h0); wr(8'h10, 16'h0); wr(8'h0C, 16'h0008);
    pin_in = 16'h0; settle(); wr(8'h34, 16'hFFFF);
    pin_in = 16'h0008; settle();
    pin_in = 16'h0000; settle();
    rdchk("R10 pre", 8'h24, 16'h0008);
    @(negedge clk); pin_in = 16'h0008;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h34; bus_wdata = 16'h0008;
    @(negedge clk); bus_wr = 1'b0;
    rdchk("R10 edge wins", 8'h24, 16'h0008);
    wr(8'h34, 16'h0008);
    rdchk("R10 later clear", 8'h24, 16'h0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); nvec++; nbad++; $display("FAIL watchdog: got hang expected finish"); end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule